// File: doc/BRIEF.md
# I2C Slave Memory Port

This block puts a byte-wide memory space of 32K locations on a two-wire serial bus as a slave. A system clock samples the bus clock and data lines through a short synchronizer. The block finds START and STOP conditions, matches the device address, and loads a 15-bit address pointer from two bytes sent by the master. It then moves data bytes in either direction, generating or sensing the ninth-bit acknowledge.

Each received data byte becomes a one-cycle write strobe on a simple synchronous memory port. Each transmitted byte is fetched with a one-cycle read strobe, and the data returns on the next clock. A read that skips the pointer write starts at whatever address the pointer holds. A power-fail input abandons any transfer, clears the pointer and makes the block deaf to the bus while it is high.

The data line is open-drain. `sda_oe` high means the block pulls the line low. The pad and pull-up are outside the block.

Top module: `i2c_mem_port`

## Requirements
- R1: A START (SDA falling while SCL is high) followed by the address byte 8'hD0 or 8'hD1, sent MSB first with the read/write flag in bit 0 (1 = read), is acknowledged: SDA is held low through the high phase of the ninth clock. SDA driven by the block changes only while SCL is low.
- R2: An address byte other than 8'hD0/8'hD1 gets no acknowledge. The block then stays idle with SDA released and no memory strobe until the next START.
- R3: After 8'hD0, the next two bytes set the pointer: first byte bits 6:0 become pointer bits 14:8, and its bit 7 is ignored; the second byte becomes bits 7:0. Both bytes are acknowledged.
- R4: Each data byte after the pointer bytes is acknowledged. It is written with a single-cycle `mem_we` at `mem_addr` = pointer, with `mem_wdata` = the byte, and the pointer then advances by one.
- R5: In a read, the byte at the pointer is sent MSB first. The pointer advances only when the master acknowledges (SDA low on the ninth clock), so the next byte comes from pointer+1. After a NACK, the pointer is not advanced.
- R6: A NACK from the master ends the read. SDA stays released and no further read strobe occurs until the next START.
- R7: A read started with 8'hD1 without a pointer write begins at the address currently held in the pointer.
- R8: During consecutive writes or reads, the pointer wraps from 15'h7FFF to 15'h0000.
- R9: While `pwr_fail` is high, the transfer is abandoned, the pointer becomes 0 on the next clock, SDA is released, no memory strobe is issued, and bus activity (including address bytes) is not acknowledged.
- R10: A repeated START at any point restarts address-byte reception and keeps the pointer value.
- R11: A STOP (SDA rising while SCL is high) returns the block to idle with SDA released.
- R12: After reset, SDA is released, no memory strobe is active and the pointer is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_fail | input | 1 | Power-fail indication; aborts and clears |
| scl_in | input | 1 | Bus clock line as seen at the pad |
| sda_in | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | 1 = pull the data line low |
| mem_addr | output | 15 | Memory address (the pointer) |
| mem_we | output | 1 | One-cycle write strobe |
| mem_wdata | output | 8 | Write data |
| mem_re | output | 1 | One-cycle read strobe; data expected on the next clock |
| mem_rdata | input | 8 | Read data, valid the clock after `mem_re` |

## Verification
The hardest states to reach from the ports are in the middle of a transfer. One is a power failure that lands partway through a byte, after the address has been acknowledged. Another is the pointer sitting at the top address just as a byte completes. The bench reaches the first by raising `pwr_fail` between two bit clocks of a running write. It then finishes the byte and checks that the acknowledge is missing, and confirms with a later current-address read that the pointer was cleared. It reaches the top address by loading 7FFFh through the pointer bytes and streaming past it in both directions. It also re-reads after a NACK to show that the pointer did not move.

// File: rtl/i2c_mem_pkg.sv
package i2c_mem_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_DEV,
    ST_ACK_DEV,
    ST_PH,
    ST_ACK_PH,
    ST_PL,
    ST_ACK_PL,
    ST_WD,
    ST_ACK_WD,
    ST_RFETCH,
    ST_RD,
    ST_RACK
  } bus_st_t;

  // Address byte matches the device when its upper seven bits equal the id.
  function automatic logic addr_hit(input logic [7:0] b, input logic [6:0] id);
    return b[7:1] == id;
  endfunction

  // Receive states shift bits in on rising SCL.
  function automatic logic is_rx(input bus_st_t s);
    return (s == ST_DEV) || (s == ST_PH) || (s == ST_PL) || (s == ST_WD);
  endfunction

  // States in which the slave drives its acknowledge.
  function automatic logic is_slave_ack(input bus_st_t s);
    return (s == ST_ACK_DEV) || (s == ST_ACK_PH) || (s == ST_ACK_PL) || (s == ST_ACK_WD);
  endfunction

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_ff, sda_ff;
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[STAGES-2:0], scl_in};
      sda_ff <= {sda_ff[STAGES-2:0], sda_in};
      scl_q  <= scl_ff[STAGES-1];
      sda_q  <= sda_ff[STAGES-1];
    end
  end

  assign scl_s     = scl_ff[STAGES-1];
  assign sda_s     = sda_ff[STAGES-1];
  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_det = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/i2c_ptr.sv
module i2c_ptr #(
  parameter int AW = 15
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          ld_hi,
  input  logic          ld_lo,
  input  logic          inc,
  input  logic [7:0]    din,
  output logic [AW-1:0] ptr
);
  localparam int HW = AW - 8;

  function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
    return p + {{(AW-1){1'b0}}, 1'b1};
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ptr <= '0;
    else if (clr)   ptr <= '0;
    else if (ld_hi) ptr[AW-1:8] <= din[HW-1:0];
    else if (ld_lo) ptr[7:0] <= din;
    else if (inc)   ptr <= step(ptr);
  end

  generate
    if (HW < 8) begin : g_drop
      logic unused_hi_bits;
      assign unused_hi_bits = ^din[7:HW];
    end
  endgenerate
endmodule

// File: rtl/i2c_mem_port.sv
module i2c_mem_port
  import i2c_mem_pkg::*;
#(
  parameter int         AW          = 15,
  parameter logic [6:0] DEV_ID      = 7'h68,
  parameter int         SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pwr_fail,
  input  logic          scl_in,
  input  logic          sda_in,
  output logic          sda_oe,
  output logic [AW-1:0] mem_addr,
  output logic          mem_we,
  output logic [7:0]    mem_wdata,
  output logic          mem_re,
  input  logic [7:0]    mem_rdata
);
  logic scl_s, sda_s, raw_rise, raw_fall, raw_start, raw_stop;

  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(raw_rise), .scl_fall(raw_fall),
    .start_det(raw_start), .stop_det(raw_stop)
  );

  // Bus events, all silenced while power is failing.
  logic ev_rise, ev_fall, ev_start, ev_stop;
  assign ev_rise  = raw_rise  & ~pwr_fail;
  assign ev_fall  = raw_fall  & ~pwr_fail;
  assign ev_start = raw_start & ~pwr_fail;
  assign ev_stop  = raw_stop  & ~pwr_fail;

  bus_st_t    st;
  logic [3:0] cnt;
  logic [7:0] sh;
  logic       m_ack;

  logic byte_done, ack_done, wr_strobe, rd_strobe;
  logic ptr_inc, ld_hi, ld_lo, ptr_load, drive;

  assign byte_done = is_rx(st) && ev_fall && (cnt == 4'd8);
  assign ack_done  = ev_fall && (cnt == 4'd1) && (is_slave_ack(st) || st == ST_RACK);
  assign wr_strobe = (st == ST_WD) && byte_done;
  assign rd_strobe = ack_done && ((st == ST_ACK_DEV && sh[0]) || (st == ST_RACK && m_ack));
  assign ptr_inc   = ((st == ST_ACK_WD) && ack_done) ||
                     ((st == ST_RACK) && ev_rise && !sda_s);
  assign ld_hi     = (st == ST_PH) && byte_done;
  assign ld_lo     = (st == ST_PL) && byte_done;
  assign ptr_load  = ld_hi | ld_lo;
  assign drive     = is_slave_ack(st) || (st == ST_RD && !sh[7]);

  i2c_ptr #(.AW(AW)) u_ptr (
    .clk(clk), .rst_n(rst_n), .clr(pwr_fail), .ld_hi(ld_hi), .ld_lo(ld_lo),
    .inc(ptr_inc), .din(sh), .ptr(mem_addr)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= ST_IDLE;
      cnt   <= '0;
      sh    <= '0;
      m_ack <= 1'b0;
    end else if (pwr_fail) begin
      st  <= ST_IDLE;
      cnt <= '0;
    end else if (ev_start) begin
      st  <= ST_DEV;
      cnt <= '0;
    end else if (ev_stop) begin
      st  <= ST_IDLE;
      cnt <= '0;
    end else begin
      case (st)
        ST_DEV, ST_PH, ST_PL, ST_WD: begin
          if (ev_rise) begin
            sh  <= {sh[6:0], sda_s};
            cnt <= cnt + 4'd1;
          end
          if (byte_done) begin
            cnt <= '0;
            case (st)
              ST_DEV:  st <= addr_hit(sh, DEV_ID) ? ST_ACK_DEV : ST_IDLE;
              ST_PH:   st <= ST_ACK_PH;
              ST_PL:   st <= ST_ACK_PL;
              default: st <= ST_ACK_WD;
            endcase
          end
        end
        ST_ACK_DEV, ST_ACK_PH, ST_ACK_PL, ST_ACK_WD: begin
          if (ev_rise) cnt <= 4'd1;
          if (ack_done) begin
            cnt <= '0;
            case (st)
              ST_ACK_DEV: st <= sh[0] ? ST_RFETCH : ST_PH;
              ST_ACK_PH:  st <= ST_PL;
              default:    st <= ST_WD;
            endcase
          end
        end
        ST_RFETCH: begin
          sh  <= mem_rdata;
          cnt <= '0;
          st  <= ST_RD;
        end
        ST_RD: begin
          if (ev_fall) begin
            sh  <= {sh[6:0], 1'b1};
            cnt <= cnt + 4'd1;
            if (cnt == 4'd7) begin
              cnt <= '0;
              st  <= ST_RACK;
            end
          end
        end
        ST_RACK: begin
          if (ev_rise) begin
            m_ack <= !sda_s;
            cnt   <= 4'd1;
          end
          if (ack_done) begin
            cnt <= '0;
            st  <= m_ack ? ST_RFETCH : ST_IDLE;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign sda_oe    = drive & ~pwr_fail;
  assign mem_we    = wr_strobe;
  assign mem_wdata = sh;
  assign mem_re    = rd_strobe;
endmodule

// File: rtl/i2c_mem_port_chk.sv
module i2c_mem_port_chk #(
  parameter int AW = 15
) (
  input logic          clk,
  input logic          rst_n,
  input logic          pwr_fail,
  input logic          scl_s,
  input logic          sda_oe,
  input logic          mem_we,
  input logic          mem_re,
  input logic [AW-1:0] mem_addr,
  input logic          ptr_load,
  input logic          start_ev,
  input logic          stop_ev
);
  a_r9_pf_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_fail |-> (!sda_oe && !mem_we && !mem_re));

  a_r9_ptr_zero: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_fail |=> (mem_addr == '0));

  a_r4_we_single: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> !mem_we);

  a_r4_we_re_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_we && mem_re));

  // R5 and R8: outside loads and clears the pointer only moves by +1, modulo 2^AW
  a_r5_ptr_step: assert property (@(posedge clk) disable iff (!rst_n)
    ((mem_addr != $past(mem_addr)) && !$past(pwr_fail) && !$past(ptr_load))
      |-> (mem_addr == AW'($past(mem_addr) + 1'b1)));

  a_r11_stop_release: assert property (@(posedge clk) disable iff (!rst_n)
    stop_ev |=> !sda_oe);

  a_r1_drive_on_low: assert property (@(posedge clk) disable iff (!rst_n)
    ((sda_oe != $past(sda_oe)) && !pwr_fail && !$past(pwr_fail) &&
     !$past(start_ev) && !$past(stop_ev)) |-> !scl_s);
endmodule

bind i2c_mem_port i2c_mem_port_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .pwr_fail(pwr_fail), .scl_s(scl_s), .sda_oe(sda_oe),
  .mem_we(mem_we), .mem_re(mem_re), .mem_addr(mem_addr), .ptr_load(ptr_load),
  .start_ev(ev_start), .stop_ev(ev_stop)
);

// File: tb/i2c_mem_port_bench.sv
module i2c_mem_port_bench;
  localparam int Q = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pwr_fail = 1'b0;
  logic m_scl = 1'b1;
  logic m_sda = 1'b1;
  logic sda_oe, mem_we, mem_re;
  logic [14:0] mem_addr;
  logic [7:0] mem_wdata;
  logic [7:0] mem_rdata = 8'h00;
  wire sda_line = m_sda & ~sda_oe;

  always #10 clk = ~clk;

  i2c_mem_port u_i2c_mem_port (
    .clk(clk), .rst_n(rst_n), .pwr_fail(pwr_fail), .scl_in(m_scl), .sda_in(sda_line),
    .sda_oe(sda_oe), .mem_addr(mem_addr), .mem_we(mem_we), .mem_wdata(mem_wdata),
    .mem_re(mem_re), .mem_rdata(mem_rdata)
  );

  function automatic logic [7:0] pat(input logic [14:0] a);
    return a[7:0] ^ {1'b0, a[14:8]};
  endfunction

  // memory model and strobe log
  int we_cnt = 0, re_cnt = 0;
  logic [14:0] log_a [16];
  logic [7:0]  log_d [16];
  always @(posedge clk) begin
    if (mem_re) begin
      mem_rdata <= pat(mem_addr);
      re_cnt <= re_cnt + 1;
    end
    if (mem_we) begin
      log_a[we_cnt % 16] <= mem_addr;
      log_d[we_cnt % 16] <= mem_wdata;
      we_cnt <= we_cnt + 1;
    end
  end

  int checks = 0, fails = 0;
  bit done = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic w(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic i2c_start();
    m_sda = 1'b1; w(Q);
    m_scl = 1'b1; w(Q);
    m_sda = 1'b0; w(Q);
    m_scl = 1'b0; w(Q);
  endtask

  task automatic i2c_stop();
    m_sda = 1'b0; w(Q);
    m_scl = 1'b1; w(Q);
    m_sda = 1'b1; w(Q);
  endtask

  task automatic send_bit(input logic b);
    m_sda = b; w(Q);
    m_scl = 1'b1; w(2*Q);
    m_scl = 1'b0; w(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output bit acked);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    m_sda = 1'b1; w(Q);
    m_scl = 1'b1; w(Q);
    acked = !sda_line;
    w(Q);
    m_scl = 1'b0; w(Q);
  endtask

  task automatic recv_byte(output logic [7:0] b, input bit mack);
    m_sda = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      w(Q);
      m_scl = 1'b1; w(Q);
      b[i] = sda_line;
      w(Q);
      m_scl = 1'b0;
    end
    w(Q);
    m_sda = !mack; w(Q);
    m_scl = 1'b1; w(2*Q);
    m_scl = 1'b0; w(Q);
    m_sda = 1'b1;
  endtask

  // set pointer: START, D0, hi, lo (acks checked)
  task automatic set_ptr(input logic [7:0] hi, input logic [7:0] lo);
    bit a;
    i2c_start();
    send_byte(8'hD0, a); check(a, "R1 write address ack", a, 1);
    send_byte(hi, a);    check(a, "R3 pointer high ack", a, 1);
    send_byte(lo, a);    check(a, "R3 pointer low ack", a, 1);
  endtask

  // current-address read of one byte, NACKed
  task automatic cur_read(input logic [14:0] exp, input string req);
    bit a;
    logic [7:0] d;
    i2c_start();
    send_byte(8'hD1, a); check(a, "R1 read address ack", a, 1);
    recv_byte(d, 1'b0);
    check(d == pat(exp), req, d, pat(exp));
    i2c_stop();
  endtask

  // {hi, lo, count, expected start address}
  localparam logic [38:0] VEC [4] = '{
    {8'h12, 8'h34, 8'd3, 15'h1234},
    {8'h92, 8'h34, 8'd2, 15'h1234},
    {8'h7F, 8'hFE, 8'd4, 15'h7FFE},
    {8'h00, 8'h00, 8'd1, 15'h0000}
  };

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not complete actual=0 expected=1");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    bit a;
    logic [7:0] d;
    int we0, re0;
    w(5);
    // R12 reset state
    check(!sda_oe, "R12 sda released in reset", sda_oe, 0);
    check(!mem_we && !mem_re, "R12 no strobe in reset", {mem_we, mem_re}, 0);
    rst_n = 1'b1; w(5);
    check(mem_addr == 15'h0, "R12 pointer zero after reset", mem_addr, 0);

    // table walk: pointer write, repeated START, sequential read
    for (int v = 0; v < 4; v++) begin
      logic [14:0] ex;
      int n;
      ex = VEC[v][14:0];
      n  = int'(VEC[v][22:15]);
      set_ptr(VEC[v][38:31], VEC[v][30:23]);
      i2c_start();
      send_byte(8'hD1, a); check(a, "R10 read address ack after repeated start", a, 1);
      for (int k = 0; k < n; k++) begin
        recv_byte(d, k != n - 1);
        check(d == pat(ex), "R5 R3 R8 sequential read data", d, pat(ex));
        if (k != n - 1) ex = ex + 15'd1;
      end
      i2c_stop();
      check(!sda_oe, "R11 sda released after stop", sda_oe, 0);
      cur_read(ex, "R7 current read at held pointer");
    end

    // R2 wrong address
    we0 = we_cnt; re0 = re_cnt;
    i2c_start();
    send_byte(8'hA0, a); check(!a, "R2 foreign address not acked", a, 0);
    send_byte(8'h55, a); check(!a, "R2 following byte not acked", a, 0);
    i2c_stop();
    check(we_cnt == we0 && re_cnt == re0, "R2 no memory strobe", we_cnt - we0 + re_cnt - re0, 0);

    // R4 writes
    we0 = we_cnt;
    set_ptr(8'h01, 8'h00);
    send_byte(8'hAA, a); check(a, "R4 data ack", a, 1);
    send_byte(8'h55, a); check(a, "R4 data ack", a, 1);
    send_byte(8'hC3, a); check(a, "R4 data ack", a, 1);
    i2c_stop();
    check(we_cnt == we0 + 3, "R4 write count", we_cnt - we0, 3);
    check(log_a[we0 % 16] == 15'h0100 && log_d[we0 % 16] == 8'hAA, "R4 first write", log_d[we0 % 16], 8'hAA);
    check(log_a[(we0 + 1) % 16] == 15'h0101 && log_d[(we0 + 1) % 16] == 8'h55, "R4 second write", log_a[(we0 + 1) % 16], 15'h0101);
    check(log_a[(we0 + 2) % 16] == 15'h0102 && log_d[(we0 + 2) % 16] == 8'hC3, "R4 third write", log_a[(we0 + 2) % 16], 15'h0102);
    cur_read(15'h0103, "R7 current read after writes");
    // R5/R6: NACK did not advance; after NACK the line stays free with no fetch
    i2c_start();
    send_byte(8'hD1, a);
    recv_byte(d, 1'b0);
    check(d == pat(15'h0103), "R5 no advance on nack", d, pat(15'h0103));
    re0 = re_cnt;
    w(4*Q);
    check(!sda_oe, "R6 sda released after nack", sda_oe, 0);
    check(re_cnt == re0, "R6 no read after nack", re_cnt - re0, 0);
    i2c_stop();

    // R8 write wrap
    we0 = we_cnt;
    set_ptr(8'h7F, 8'hFF);
    send_byte(8'h11, a);
    send_byte(8'h22, a);
    i2c_stop();
    check(log_a[we0 % 16] == 15'h7FFF, "R8 write at top", log_a[we0 % 16], 15'h7FFF);
    check(log_a[(we0 + 1) % 16] == 15'h0000 && log_d[(we0 + 1) % 16] == 8'h22, "R8 write wraps to zero", log_a[(we0 + 1) % 16], 0);

    // R10 repeated start keeps pointer
    set_ptr(8'h02, 8'h00);
    send_byte(8'h77, a);
    i2c_start();
    send_byte(8'hD1, a); check(a, "R10 ack after restart", a, 1);
    recv_byte(d, 1'b0);
    check(d == pat(15'h0201), "R10 pointer kept across restart", d, pat(15'h0201));
    i2c_stop();

    // R9 power fail mid byte
    we0 = we_cnt;
    set_ptr(8'h03, 8'h45);
    send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
    pwr_fail = 1'b1; w(2);
    check(mem_addr == 15'h0, "R9 pointer cleared", mem_addr, 0);
    check(!sda_oe, "R9 sda released", sda_oe, 0);
    for (int i = 0; i < 5; i++) send_bit(1'b0);
    m_sda = 1'b1; w(Q); m_scl = 1'b1; w(Q);
    check(sda_line, "R9 byte not acked during power fail", sda_line, 1);
    w(Q); m_scl = 1'b0; w(Q);
    i2c_start();
    send_byte(8'hD0, a); check(!a, "R9 address ignored during power fail", a, 0);
    i2c_stop();
    check(we_cnt == we0, "R9 no write during power fail", we_cnt - we0, 0);
    pwr_fail = 1'b0; w(Q);
    cur_read(15'h0000, "R9 read from cleared pointer");

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule